// File: doc/BRIEF.md
# Multiplexed-Bus Control Register Interface

This block is the host-facing control port of a modem-style peripheral. A host reaches it over an 8-bit multiplexed address/data bus with four strobes: address latch enable, active-low chip select, active-low read and active-low write. The block holds three writable 8-bit control registers and one read-only register of sticky detect flags. It signals pending detect events on an open-drain interrupt line and drives a clock output that software can switch between the crystal clock and a divided baud-rate clock.

All strobes are sampled on the crystal clock `clk`. Detect events come from outside the block as single-cycle pulses on `det_in`. The bus is modelled as separate input and output lanes plus an output enable, so a pad ring can build the tri-state driver. The interrupt is modelled as a pull-low enable that never drives high.

Top module: `mbus_ctl_if`

## Requirements
- R1: On the clock edge where `ale` is first seen low after being high, the block captures `ad_in[2:0]` as the register address and captures the level of `cs_n` as the selection for the access.
- R2: If `cs_n` was high at that capture, `ad_oe` stays 0 and no register changes, whatever `rd_n` and `wr_n` do.
- R3: `ad_oe` is 1 only while `rd_n` is low and the captured selection is active. While it is 1, `ad_out` carries the addressed register.
- R4: A selected write stores `ad_in` into the addressed register on the clock edge where `wr_n` is first seen high after being low. The map is: address 0 is control A, address 1 is control B, address 3 is the tone register.
- R5: Address 2 (detect) ignores writes. Addresses 4 to 7 read as 0x00 and ignore writes.
- R6: A pulse on bit i of `det_in` sets detect flag i, which reads back as bit i at address 2 (upper bits 0). `irq_pull` is 1 whenever any flag is set.
- R7: All detect flags clear on the edge where `rd_n` is first seen high after a selected read of address 2, and `irq_pull` then returns to 0. A flag whose pulse arrives in that same cycle stays set.
- R8: An active-high `rst` clears control A, control B, tone, all detect flags and the captured selection, and selects the crystal clock on `clk_out`.
- R9: Bit 4 of control B selects the baud clock for `clk_out` (0 is crystal). The selector changes only on a falling crystal edge while the baud clock is low, so no pulse on `clk_out` is shorter than half a crystal period.
- R10: Bits [1:0] of control B set the rate r. The baud clock period is 2·(HALF_MIN << (3−r)) crystal cycles, which is 4 cycles at r=3 and 32 cycles at r=0 with the default HALF_MIN=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock, samples every strobe |
| rst | input | 1 | Active-high reset |
| ale | input | 1 | Address latch enable, captures on its falling edge |
| cs_n | input | 1 | Active-low chip select, sampled with the address |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ad_in | input | 8 | Bus lanes seen by the block (address, then write data) |
| ad_out | output | 8 | Read data towards the bus |
| ad_oe | output | 1 | Bus drive enable, 0 means released |
| det_in | input | 4 | One-cycle detect event pulses |
| irq_pull | output | 1 | Open-drain interrupt pull-low enable |
| clk_out | output | 1 | Crystal clock or baud clock, chosen by software |

## Verification
The hardest case to reach from the ports is a detect pulse that lands in the exact cycle that clears the flags. The bench raises `rd_n` and asserts the pulse at the same falling clock edge, then reads the detect register a second time to show the new flag survived. The glitch-free clock switch is checked by a monitor that measures every high and low width of `clk_out` while software switches the select bit in both directions.

// File: rtl/mbus_pkg.sv
`timescale 1ns/1ps
package mbus_pkg;
  localparam logic [2:0] ADR_CTLA = 3'd0;
  localparam logic [2:0] ADR_CTLB = 3'd1;
  localparam logic [2:0] ADR_DET  = 3'd2;
  localparam logic [2:0] ADR_TONE = 3'd3;
  localparam int CLKSEL_BIT = 4;

  // Half period of the baud clock in crystal cycles: base << (3 - rate).
  function automatic int unsigned baud_half(input int unsigned base, input logic [1:0] rate);
    return base << (2'd3 - rate);
  endfunction
endpackage

// File: rtl/mbus_latch.sv
`timescale 1ns/1ps
module mbus_latch (
  input  logic       clk,
  input  logic       rst,
  input  logic       ale,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [2:0] adr_in,
  output logic [2:0] adr_q,
  output logic       sel_q,
  output logic       wr_commit,
  output logic       rd_end
);
  logic ale_d, rd_d, wr_d;
  logic ale_fall;

  assign ale_fall  = ale_d & ~ale;
  assign wr_commit = sel_q & ~wr_d & wr_n;
  assign rd_end    = sel_q & ~rd_d & rd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_d <= 1'b0;
      rd_d  <= 1'b1;
      wr_d  <= 1'b1;
      adr_q <= '0;
      sel_q <= 1'b0;
    end else begin
      ale_d <= ale;
      rd_d  <= rd_n;
      wr_d  <= wr_n;
      if (ale_fall) begin
        adr_q <= adr_in;
        sel_q <= ~cs_n;
      end
    end
  end
endmodule

// File: rtl/mbus_detect.sv
`timescale 1ns/1ps
module mbus_detect #(
  parameter int DET_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DET_W-1:0] det_in,
  input  logic             clr,
  output logic [DET_W-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (clr ? '0 : flags) | det_in;
  end
endmodule

// File: rtl/mbus_clkgen.sv
`timescale 1ns/1ps
module mbus_clkgen #(
  parameter int HALF_MIN = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate,
  input  logic       want_baud,
  output logic       baud_q,
  output logic       use_baud,
  output logic       clk_out
);
  import mbus_pkg::*;
  localparam int HALF_MAX = HALF_MIN << 3;
  localparam int CNT_W    = $clog2(HALF_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(baud_half(HALF_MIN, rate) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      baud_q <= 1'b0;
    end else if (cnt >= limit) begin
      cnt    <= '0;
      baud_q <= ~baud_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Select moves only while crystal is low (falling edge) and baud is low.
  always_ff @(negedge clk) begin
    if (rst)          use_baud <= 1'b0;
    else if (!baud_q) use_baud <= want_baud;
  end

  assign clk_out = use_baud ? baud_q : clk;
endmodule

// File: rtl/mbus_ctl_if.sv
`timescale 1ns/1ps
module mbus_ctl_if #(
  parameter int DET_W    = 4,
  parameter int HALF_MIN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ale,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [7:0]       ad_in,
  output logic [7:0]       ad_out,
  output logic             ad_oe,
  input  logic [DET_W-1:0] det_in,
  output logic             irq_pull,
  output logic             clk_out
);
  import mbus_pkg::*;

  logic [2:0]       adr_q;
  logic             sel_q, wr_commit, rd_end, det_clr;
  logic [7:0]       ctla_q, ctlb_q, tone_q;
  logic [DET_W-1:0] flags;
  logic             baud_q, use_baud;

  mbus_latch u_latch (
    .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .adr_in(ad_in[2:0]), .adr_q(adr_q), .sel_q(sel_q),
    .wr_commit(wr_commit), .rd_end(rd_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctla_q <= '0;
      ctlb_q <= '0;
      tone_q <= '0;
    end else if (wr_commit) begin
      case (adr_q)
        ADR_CTLA: ctla_q <= ad_in;
        ADR_CTLB: ctlb_q <= ad_in;
        ADR_TONE: tone_q <= ad_in;
        default: ;
      endcase
    end
  end

  assign det_clr = rd_end && (adr_q == ADR_DET);

  mbus_detect #(.DET_W(DET_W)) u_det (
    .clk(clk), .rst(rst), .det_in(det_in), .clr(det_clr), .flags(flags)
  );

  always_comb begin
    case (adr_q)
      ADR_CTLA: ad_out = ctla_q;
      ADR_CTLB: ad_out = ctlb_q;
      ADR_DET:  ad_out = 8'(flags);
      ADR_TONE: ad_out = tone_q;
      default:  ad_out = 8'h00;
    endcase
  end

  assign ad_oe    = sel_q & ~rd_n;
  assign irq_pull = |flags;

  mbus_clkgen #(.HALF_MIN(HALF_MIN)) u_clk (
    .clk(clk), .rst(rst), .rate(ctlb_q[1:0]), .want_baud(ctlb_q[CLKSEL_BIT]),
    .baud_q(baud_q), .use_baud(use_baud), .clk_out(clk_out)
  );
endmodule

// File: rtl/mbus_ctl_if_chk.sv
`timescale 1ns/1ps
module mbus_ctl_if_chk #(
  parameter int DET_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [DET_W-1:0] det_in,
  input logic             irq_pull,
  input logic             wr_commit,
  input logic             wr_n,
  input logic             sel_q,
  input logic             ad_oe,
  input logic [7:0]       ctla_q,
  input logic [7:0]       ctlb_q,
  input logic [7:0]       tone_q,
  input logic             det_clr,
  input logic             use_baud,
  input logic             baud_q
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R8: the cycle after reset every control register reads zero
  always_ff @(posedge clk) begin
    if (rst_d && rst)
      p_reset_clears_r8: assert (ctla_q == 8'h00 && ctlb_q == 8'h00 && tone_q == 8'h00 && !irq_pull && !use_baud);
  end

  p_deselect_no_write_r2: assert property (@(posedge clk) disable iff (rst)
    (!sel_q && wr_n) |=> ($stable(ctla_q) && $stable(ctlb_q) && $stable(tone_q)));

  p_deselect_no_drive_r2: assert property (@(posedge clk) disable iff (rst)
    !sel_q |-> !ad_oe);

  p_det_raises_irq_r6: assert property (@(posedge clk) disable iff (rst)
    (|det_in) |=> irq_pull);

  p_irq_held_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_pull && !det_clr) |=> irq_pull);

  p_irq_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (det_clr && det_in == '0) |=> !irq_pull);

  p_write_commit_sel_r4: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> sel_q);

  p_clk_switch_quiet_r9: assert property (@(negedge clk) disable iff (rst)
    (use_baud != $past(use_baud)) |-> !$past(baud_q));
endmodule

bind mbus_ctl_if mbus_ctl_if_chk #(.DET_W(DET_W)) u_chk (
  .clk(clk), .rst(rst), .det_in(det_in), .irq_pull(irq_pull),
  .wr_commit(wr_commit), .wr_n(wr_n), .sel_q(sel_q), .ad_oe(ad_oe),
  .ctla_q(ctla_q), .ctlb_q(ctlb_q), .tone_q(tone_q), .det_clr(det_clr),
  .use_baud(use_baud), .baud_q(baud_q)
);

// File: tb/mbus_ctl_if_bench.sv
`timescale 1ns/1ps
module mbus_ctl_if_bench;
  localparam real TCK = 8.0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] ad_in = 8'h00;
  logic [3:0] det_in = 4'h0;
  logic [7:0] ad_out;
  logic       ad_oe, irq_pull, clk_out;

  int checks = 0;
  int errors = 0;

  always #(TCK/2) clk = ~clk;

  mbus_ctl_if u_mbus_ctl_if (
    .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .det_in(det_in),
    .irq_pull(irq_pull), .clk_out(clk_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Width monitor on clk_out
  bit  mon_on = 0;
  real last_edge = 0.0, min_w = 1.0e9;
  always @(clk_out) begin
    if (mon_on && $realtime - last_edge < min_w) min_w = $realtime - last_edge;
    last_edge = $realtime;
  end

  task automatic addr_phase(input logic [2:0] a, input logic sel);
    @(negedge clk); ale = 1'b1; ad_in = {5'b0, a}; cs_n = ~sel;
    @(negedge clk); ale = 1'b0;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input logic sel);
    addr_phase(a, sel);
    ad_in = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [2:0] a, input logic sel,
                          output logic [7:0] d, output logic oe, output logic oe_idle);
    addr_phase(a, sel);
    oe_idle = ad_oe;
    rd_n = 1'b0;
    @(negedge clk); d = ad_out; oe = ad_oe;
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_det(input logic [3:0] m);
    @(negedge clk); det_in = m;
    @(negedge clk); det_in = 4'h0;
  endtask

  task automatic t_reset_state();
    logic [7:0] d; logic oe, oei;
    check("R8 irq after reset", irq_pull, 1'b0);
    check("R3 oe after reset", ad_oe, 1'b0);
    @(posedge clk); #1 check("R8 clk_out crystal high", clk_out, 1'b1);
    @(negedge clk); #1 check("R8 clk_out crystal low", clk_out, 1'b0);
    bus_read(3'd0, 1'b1, d, oe, oei); check("R8 ctlA zero", d, 8'h00);
    bus_read(3'd1, 1'b1, d, oe, oei); check("R8 ctlB zero", d, 8'h00);
    bus_read(3'd3, 1'b1, d, oe, oei); check("R8 tone zero", d, 8'h00);
  endtask

  task automatic t_write_read();
    logic [7:0] d; logic oe, oei;
    bus_write(3'd0, 8'hA5, 1'b1);
    bus_write(3'd1, 8'h02, 1'b1);
    bus_write(3'd3, 8'h3C, 1'b1);
    bus_read(3'd0, 1'b1, d, oe, oei);
    check("R4 ctlA readback", d, 8'hA5); check("R3 oe during read", oe, 1'b1);
    check("R3 oe before rd low", oei, 1'b0);
    bus_read(3'd1, 1'b1, d, oe, oei); check("R4 ctlB readback", d, 8'h02);
    bus_read(3'd3, 1'b1, d, oe, oei); check("R1 R4 tone readback", d, 8'h3C);
    @(negedge clk); check("R3 oe released after read", ad_oe, 1'b0);
  endtask

  task automatic t_unmapped();
    logic [7:0] d; logic oe, oei;
    bus_write(3'd5, 8'hFF, 1'b1);
    bus_read(3'd5, 1'b1, d, oe, oei); check("R5 unmapped reads zero", d, 8'h00);
    bus_write(3'd2, 8'h0F, 1'b1);
    bus_read(3'd2, 1'b1, d, oe, oei); check("R5 detect ignores write", d, 8'h00);
    check("R5 irq after detect write", irq_pull, 1'b0);
    bus_read(3'd0, 1'b1, d, oe, oei); check("R5 ctlA untouched", d, 8'hA5);
  endtask

  task automatic t_deselected();
    logic [7:0] d; logic oe, oei;
    bus_write(3'd0, 8'h11, 1'b0);
    bus_read(3'd0, 1'b0, d, oe, oei); check("R2 no drive when deselected", oe, 1'b0);
    bus_read(3'd0, 1'b1, d, oe, oei); check("R2 write ignored when deselected", d, 8'hA5);
  endtask

  task automatic t_detect();
    logic [7:0] d; logic oe, oei;
    pulse_det(4'b0100);
    check("R6 irq after pulse", irq_pull, 1'b1);
    pulse_det(4'b0001);
    repeat (3) @(negedge clk);
    check("R6 irq held", irq_pull, 1'b1);
    bus_read(3'd2, 1'b1, d, oe, oei); check("R6 flags readback", d, 8'h05);
    check("R7 irq cleared by read", irq_pull, 1'b0);
    bus_read(3'd2, 1'b1, d, oe, oei); check("R7 flags cleared", d, 8'h00);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    pulse_det(4'b0010);
    addr_phase(3'd2, 1'b1);
    rd_n = 1'b0;
    @(negedge clk); d = ad_out;
    check("R7 first read sees flag", d, 8'h02);
    rd_n = 1'b1; det_in = 4'b1000;
    @(negedge clk); det_in = 4'h0;
    check("R7 irq kept by same-cycle pulse", irq_pull, 1'b1);
    begin logic oe, oei; bus_read(3'd2, 1'b1, d, oe, oei); end
    check("R7 same-cycle flag survives", d, 8'h08);
  endtask

  task automatic measure_period(output real p);
    real t0;
    @(posedge clk_out); @(posedge clk_out); t0 = $realtime;
    @(posedge clk_out); p = $realtime - t0;
  endtask

  task automatic t_clock_switch();
    real p;
    mon_on = 1; min_w = 1.0e9;
    bus_write(3'd1, 8'h13, 1'b1);   // select baud, rate 3
    repeat (20) @(negedge clk);
    measure_period(p); check("R10 rate3 period ns", int'(p), 32);
    bus_write(3'd1, 8'h10, 1'b1);   // rate 0
    repeat (80) @(negedge clk);
    measure_period(p); check("R10 rate0 period ns", int'(p), 256);
    bus_write(3'd1, 8'h00, 1'b1);   // back to crystal
    repeat (80) @(negedge clk);
    measure_period(p); check("R9 crystal period ns", int'(p), 8);
    bus_write(3'd1, 8'h12, 1'b1);
    repeat (40) @(negedge clk);
    bus_write(3'd1, 8'h02, 1'b1);
    repeat (40) @(negedge clk);
    mon_on = 0;
    check("R9 no short pulse", (min_w >= 3.999) ? 1 : 0, 1);
  endtask

  task automatic t_reset_again();
    logic [7:0] d; logic oe, oei;
    bus_write(3'd1, 8'h13, 1'b1);
    bus_write(3'd3, 8'h77, 1'b1);
    pulse_det(4'b0001);
    repeat (10) @(negedge clk);
    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0;
    check("R8 irq cleared by reset", irq_pull, 1'b0);
    @(negedge clk); #1 check("R8 crystal after reset", clk_out, 1'b0);
    bus_read(3'd3, 1'b1, d, oe, oei); check("R8 tone cleared", d, 8'h00);
    bus_read(3'd1, 1'b1, d, oe, oei); check("R8 ctlB cleared", d, 8'h00);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    bus_read(3'd0, 1'b1, d, oe, oei); check("R8 selection cleared, oe driven only with new ale", oei, 1'b0);
  endtask

  bit done = 0;
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_write_read();
    t_unmapped();
    t_deselected();
    t_detect();
    t_same_cycle();
    t_clock_switch();
    t_reset_again();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(200000 * TCK);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule